// File: doc/BRIEF.md
# I2C Master Transfer Control Unit

This unit holds the software-visible control word of an I2C master and runs the byte-level sequence around it. Software writes a target address, a direction, the 10-bit addressing options, a byte count and the mode bits that choose what happens at the end of a transfer. It then sets command bits to request a start or a stop. The unit turns these commands into single-cycle start, repeated-start and stop requests to a bit-level bus engine. It counts down the bytes that the engine reports as moved, and it chooses the acknowledge value for each received byte.

Four command bits (start, stop, slave NACK and error-check byte) can only be set by software. Each is cleared by hardware on its own group of events from the bus engine, or when the peripheral enable is low. When the byte counter reaches zero, one of three things follows. With reload mode on, the unit stalls until software writes a new count. With auto-end on, it issues a stop. Otherwise it reports transfer complete and waits for software to request a repeated start or a stop. A register write that follows an accepted write too closely is held off with a wait output.

Top module: `i2c_xfer_ctrl`

## Requirements
- R1: After reset, the control word reads as zero, no command pulse is issued, and the master-active, transfer-complete and reload-pending flags are low.
- R2: Control word fields: target address bits 9:0, read direction bit 10, 10-bit mode bit 11, header-only bit 12, start bit 13, stop bit 14, NACK bit 15, byte count bits 23:16, reload bit 24, auto-end bit 25, error-check-byte bit 26. Bits 31:27 read as zero. A read request returns the word on reg_rdata one cycle later.
- R3: Writing 1 to start, stop, NACK or error-check-byte sets that bit. Writing 0 to any of them leaves it unchanged.
- R4: While the start bit is set, written values for the direction, 10-bit mode and header-only bits are ignored.
- R5: While the stored reload bit is 1, writing 1 to start or to error-check-byte has no effect.
- R6: Start is requested with a cmd_start pulse only while bus_busy is low. The start bit is cleared by address-sent, arbitration loss, timeout or a low enable. Arbitration loss or timeout also returns the master to inactive.
- R7: Stop clears on stop-detect or low enable. NACK clears on nack-sent, stop-detect, address-match or low enable. Error-check-byte clears on its transfer-done, stop-detect, address-match or low enable. A clear event wins over a write in the same cycle.
- R8: On address-sent, the counter loads the written byte count, and each byte-done decrements it. At zero with reload set, reload-pending rises and holds until a write is accepted. That write's byte count reloads the counter and the transfer resumes.
- R9: At zero with reload clear and auto-end set, one cmd_stop pulse is issued. The master stays active until stop-detect.
- R10: At zero with reload and auto-end clear, transfer-complete rises. A later start bit gives one cmd_rstart pulse, and a later stop bit gives one cmd_stop pulse.
- R11: nack_out (1 = NACK) is registered. It is 1 for the last byte of a master read when reload is clear. Otherwise, with error-check-byte set and pec_phase high, it follows pec_bad. Otherwise it follows the NACK bit.
- R12: A write presented within WR_LAT cycles after an accepted write gets reg_wait and is not applied until accepted. Wait lasts at most WR_LAT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Peripheral enable; low clears command bits and sequencer |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_wdata | input | 32 | Write data |
| reg_wait | output | 1 | Write held off this cycle |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| bus_busy | input | 1 | Bus currently owned by another transfer |
| ev_addr_sent | input | 1 | Start and address phase finished |
| ev_byte_done | input | 1 | One data byte transferred |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_timeout | input | 1 | Timeout error |
| ev_stop_det | input | 1 | Stop condition seen on the bus |
| ev_addr_match | input | 1 | Own address matched (slave) |
| ev_nack_sent | input | 1 | NACK has been driven |
| ev_pec_done | input | 1 | Error-check byte transferred |
| pec_phase | input | 1 | Byte being acknowledged is the error-check byte |
| pec_bad | input | 1 | Received error-check byte mismatched |
| cmd_start | output | 1 | Pulse: issue start once bus free |
| cmd_rstart | output | 1 | Pulse: issue repeated start |
| cmd_stop | output | 1 | Pulse: issue stop |
| tgt_addr | output | 10 | Target address |
| addr_10b | output | 1 | 10-bit addressing |
| hdr_only | output | 1 | Send 10-bit header only for read |
| dir_read | output | 1 | Transfer direction is read |
| nack_out | output | 1 | Acknowledge value for current received byte |
| master_active | output | 1 | Sequencer owns a transfer |
| tc_flag | output | 1 | Transfer complete, awaiting software |
| tcr_flag | output | 1 | Reload pending, awaiting new count |
| bytes_left | output | 8 | Remaining byte count |

## Verification
The hardest states to reach are the reload stall and the repeated start, because each needs a full chain first. Software must write a start, the engine must report the address as sent, and the exact number of byte-done events must follow before the counter hits zero in the chosen mode. The stimulus scripts each chain event by event. It queues the expected command pulse before the step that triggers it and checks the flags while the unit waits for software. The write hold-off is reached by issuing two writes back to back, and the wait cycles of the second are counted.

// File: rtl/i2c_xfer_pkg.sv
package i2c_xfer_pkg;
  localparam int REG_W       = 32;
  localparam int ADDR_W      = 10;
  localparam int CNT_W       = 8;
  localparam int TGT_LSB     = 0;
  localparam int DIR_BIT     = 10;
  localparam int A10_BIT     = 11;
  localparam int HDR_BIT     = 12;
  localparam int GO_BIT      = 13;
  localparam int END_BIT     = 14;
  localparam int NAK_BIT     = 15;
  localparam int CNT_LSB     = 16;
  localparam int RLD_BIT     = 24;
  localparam int AUTO_BIT    = 25;
  localparam int CHK_BIT     = 26;
  localparam int USED_W      = 27;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_XFER, ST_TC, ST_TCR, ST_STOP
  } seq_state_t;
endpackage

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
  import i2c_xfer_pkg::*;
#(
  parameter int WR_LAT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic               reg_wait,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               ev_addr_sent,
  input  logic               ev_arb_lost,
  input  logic               ev_timeout,
  input  logic               ev_stop_det,
  input  logic               ev_addr_match,
  input  logic               ev_nack_sent,
  input  logic               ev_pec_done,
  output logic               wr_acc,
  output logic [CNT_W-1:0]   wr_cnt,
  output logic [ADDR_W-1:0]  tgt_q,
  output logic               dir_q,
  output logic               a10_q,
  output logic               hdr_q,
  output logic               go_q,
  output logic               end_q,
  output logic               nak_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               rld_q,
  output logic               auto_q,
  output logic               chk_q
);
  localparam int LAT_W = $clog2(WR_LAT + 2);

  logic [LAT_W-1:0] busy_cnt;
  logic [LAT_W-1:0] wait_run;
  logic             clr_go, clr_end, clr_nak, clr_chk;
  logic [REG_W-1:0] image;
  logic             unused_hi;

  assign unused_hi = ^reg_wdata[REG_W-1:USED_W];

  assign wr_acc   = reg_wr && (busy_cnt == '0);
  assign reg_wait = reg_wr && (busy_cnt != '0);
  assign wr_cnt   = reg_wdata[CNT_LSB +: CNT_W];

  assign clr_go  = !en || ev_addr_sent || ev_arb_lost || ev_timeout;
  assign clr_end = !en || ev_stop_det;
  assign clr_nak = !en || ev_nack_sent || ev_stop_det || ev_addr_match;
  assign clr_chk = !en || ev_pec_done  || ev_stop_det || ev_addr_match;

  always_comb begin
    image                       = '0;
    image[TGT_LSB +: ADDR_W]    = tgt_q;
    image[DIR_BIT]              = dir_q;
    image[A10_BIT]              = a10_q;
    image[HDR_BIT]              = hdr_q;
    image[GO_BIT]               = go_q;
    image[END_BIT]              = end_q;
    image[NAK_BIT]              = nak_q;
    image[CNT_LSB +: CNT_W]     = cnt_q;
    image[RLD_BIT]              = rld_q;
    image[AUTO_BIT]             = auto_q;
    image[CHK_BIT]              = chk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt  <= '0;
      wait_run  <= '0;
      reg_rdata <= '0;
      tgt_q     <= '0;
      dir_q     <= 1'b0;
      a10_q     <= 1'b0;
      hdr_q     <= 1'b0;
      go_q      <= 1'b0;
      end_q     <= 1'b0;
      nak_q     <= 1'b0;
      cnt_q     <= '0;
      rld_q     <= 1'b0;
      auto_q    <= 1'b0;
      chk_q     <= 1'b0;
    end else begin
      if (wr_acc)
        busy_cnt <= LAT_W'(WR_LAT);
      else if (busy_cnt != '0)
        busy_cnt <= busy_cnt - 1'b1;
      wait_run <= reg_wait ? wait_run + 1'b1 : '0;

      if (wr_acc) begin
        tgt_q  <= reg_wdata[TGT_LSB +: ADDR_W];
        cnt_q  <= wr_cnt;
        rld_q  <= reg_wdata[RLD_BIT];
        auto_q <= reg_wdata[AUTO_BIT];
        if (!go_q) begin
          dir_q <= reg_wdata[DIR_BIT];
          a10_q <= reg_wdata[A10_BIT];
          hdr_q <= reg_wdata[HDR_BIT];
        end
      end

      go_q  <= clr_go  ? 1'b0 : (go_q  | (wr_acc & reg_wdata[GO_BIT]  & !rld_q));
      end_q <= clr_end ? 1'b0 : (end_q | (wr_acc & reg_wdata[END_BIT]));
      nak_q <= clr_nak ? 1'b0 : (nak_q | (wr_acc & reg_wdata[NAK_BIT]));
      chk_q <= clr_chk ? 1'b0 : (chk_q | (wr_acc & reg_wdata[CHK_BIT] & !rld_q));

      if (reg_rd)
        reg_rdata <= image;
    end
  end

  // R6: start request dropped after any of its clearing events
  assert_go_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_addr_sent || ev_arb_lost || ev_timeout || !en) |=> !go_q);

  // R7: low enable wipes the other self-clearing bits
  assert_en_wipe_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(end_q || nak_q || chk_q));

  // R4: address mode bits frozen while a start is pending
  assert_addr_lock_R4: assert property (@(posedge clk) disable iff (rst)
    go_q |=> $stable({dir_q, a10_q, hdr_q}));

  // R12: hold-off never exceeds the write latency
  assert_wait_bound_R12: assert property (@(posedge clk) disable iff (rst)
    reg_wait |-> (wait_run < LAT_W'(WR_LAT)));
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
  import i2c_xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             go_q,
  input  logic             end_q,
  input  logic             rld_q,
  input  logic             auto_q,
  input  logic             dir_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             wr_acc,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             bus_busy,
  input  logic             ev_addr_sent,
  input  logic             ev_arb_lost,
  input  logic             ev_timeout,
  input  logic             ev_stop_det,
  input  logic             ev_byte_done,
  output logic             cmd_start,
  output logic             cmd_rstart,
  output logic             cmd_stop,
  output logic             master_active,
  output logic             tc_flag,
  output logic             tcr_flag,
  output logic [CNT_W-1:0] bytes_left,
  output logic             rx_last
);
  seq_state_t       st;
  logic [CNT_W-1:0] left;

  assign master_active = (st != ST_IDLE);
  assign tc_flag       = (st == ST_TC);
  assign tcr_flag      = (st == ST_TCR);
  assign bytes_left    = left;
  assign rx_last       = (st == ST_XFER) && dir_q && !rld_q && (left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st         <= ST_IDLE;
      left       <= '0;
      cmd_start  <= 1'b0;
      cmd_rstart <= 1'b0;
      cmd_stop   <= 1'b0;
    end else begin
      cmd_start  <= 1'b0;
      cmd_rstart <= 1'b0;
      cmd_stop   <= 1'b0;
      if ((ev_arb_lost || ev_timeout) && st != ST_IDLE) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: if (go_q && !bus_busy) begin
            st        <= ST_ADDR;
            cmd_start <= 1'b1;
          end
          ST_ADDR: if (ev_addr_sent) begin
            st   <= ST_XFER;
            left <= cnt_q;
          end
          ST_XFER: begin
            if (left == '0) begin
              if (rld_q) begin
                st <= ST_TCR;
              end else if (auto_q) begin
                st       <= ST_STOP;
                cmd_stop <= 1'b1;
              end else begin
                st <= ST_TC;
              end
            end else if (ev_byte_done) begin
              left <= left - 1'b1;
            end
          end
          ST_TC: begin
            if (end_q) begin
              st       <= ST_STOP;
              cmd_stop <= 1'b1;
            end else if (go_q) begin
              st         <= ST_ADDR;
              cmd_rstart <= 1'b1;
            end
          end
          ST_TCR: if (wr_acc) begin
            left <= wr_cnt;
            st   <= ST_XFER;
          end
          ST_STOP: if (ev_stop_det) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R9, R10: at most one bus command per cycle
  assert_one_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_start, cmd_rstart, cmd_stop}));

  // R8: reload stall holds until a write is accepted
  assert_tcr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (tcr_flag && en && !wr_acc && !ev_arb_lost && !ev_timeout) |=> tcr_flag);
endmodule

// File: rtl/i2c_ack_sel.sv
module i2c_ack_sel (
  input  logic clk,
  input  logic rst,
  input  logic rx_last,
  input  logic chk_q,
  input  logic pec_phase,
  input  logic pec_bad,
  input  logic nak_q,
  output logic nack_out
);
  always_ff @(posedge clk) begin
    if (rst)
      nack_out <= 1'b0;
    else if (rx_last)
      nack_out <= 1'b1;
    else if (chk_q && pec_phase)
      nack_out <= pec_bad;
    else
      nack_out <= nak_q;
  end

  // R11: last byte of a master read is always refused
  assert_last_nack_R11: assert property (@(posedge clk) disable iff (rst)
    rx_last |=> nack_out);
endmodule

// File: rtl/i2c_xfer_ctrl.sv
module i2c_xfer_ctrl
  import i2c_xfer_pkg::*;
#(
  parameter int WR_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic              reg_wait,
  output logic [31:0]       reg_rdata,
  input  logic              bus_busy,
  input  logic              ev_addr_sent,
  input  logic              ev_byte_done,
  input  logic              ev_arb_lost,
  input  logic              ev_timeout,
  input  logic              ev_stop_det,
  input  logic              ev_addr_match,
  input  logic              ev_nack_sent,
  input  logic              ev_pec_done,
  input  logic              pec_phase,
  input  logic              pec_bad,
  output logic              cmd_start,
  output logic              cmd_rstart,
  output logic              cmd_stop,
  output logic [9:0]        tgt_addr,
  output logic              addr_10b,
  output logic              hdr_only,
  output logic              dir_read,
  output logic              nack_out,
  output logic              master_active,
  output logic              tc_flag,
  output logic              tcr_flag,
  output logic [7:0]        bytes_left
);
  logic             wr_acc;
  logic [CNT_W-1:0] wr_cnt;
  logic             go_q, end_q, nak_q, rld_q, auto_q, chk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rx_last;

  i2c_ctl_reg #(.WR_LAT(WR_LAT)) u_reg (
    .clk(clk), .rst(rst), .en(en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_wait(reg_wait), .reg_rdata(reg_rdata),
    .ev_addr_sent(ev_addr_sent), .ev_arb_lost(ev_arb_lost),
    .ev_timeout(ev_timeout), .ev_stop_det(ev_stop_det),
    .ev_addr_match(ev_addr_match), .ev_nack_sent(ev_nack_sent),
    .ev_pec_done(ev_pec_done),
    .wr_acc(wr_acc), .wr_cnt(wr_cnt),
    .tgt_q(tgt_addr), .dir_q(dir_read), .a10_q(addr_10b), .hdr_q(hdr_only),
    .go_q(go_q), .end_q(end_q), .nak_q(nak_q), .cnt_q(cnt_q),
    .rld_q(rld_q), .auto_q(auto_q), .chk_q(chk_q)
  );

  i2c_byte_seq u_seq (
    .clk(clk), .rst(rst), .en(en),
    .go_q(go_q), .end_q(end_q), .rld_q(rld_q), .auto_q(auto_q),
    .dir_q(dir_read), .cnt_q(cnt_q), .wr_acc(wr_acc), .wr_cnt(wr_cnt),
    .bus_busy(bus_busy), .ev_addr_sent(ev_addr_sent),
    .ev_arb_lost(ev_arb_lost), .ev_timeout(ev_timeout),
    .ev_stop_det(ev_stop_det), .ev_byte_done(ev_byte_done),
    .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
    .master_active(master_active), .tc_flag(tc_flag), .tcr_flag(tcr_flag),
    .bytes_left(bytes_left), .rx_last(rx_last)
  );

  i2c_ack_sel u_ack (
    .clk(clk), .rst(rst), .rx_last(rx_last), .chk_q(chk_q),
    .pec_phase(pec_phase), .pec_bad(pec_bad), .nak_q(nak_q),
    .nack_out(nack_out)
  );
endmodule

// File: tb/test_i2c_xfer_ctrl.sv
module test_i2c_xfer_ctrl;
  logic clk = 0, rst = 1, en = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = 0;
  logic reg_wait;
  logic [31:0] reg_rdata;
  logic bus_busy = 0, ev_addr_sent = 0, ev_byte_done = 0, ev_arb_lost = 0;
  logic ev_timeout = 0, ev_stop_det = 0, ev_addr_match = 0, ev_nack_sent = 0;
  logic ev_pec_done = 0, pec_phase = 0, pec_bad = 0;
  logic cmd_start, cmd_rstart, cmd_stop, addr_10b, hdr_only, dir_read;
  logic nack_out, master_active, tc_flag, tcr_flag;
  logic [9:0] tgt_addr;
  logic [7:0] bytes_left;

  int checks = 0, fails = 0, stalls = 0;
  bit done = 0;
  int exp_q[$];
  logic [31:0] v;

  always #2 clk = ~clk;

  i2c_xfer_ctrl i_i2c_xfer_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d; stalls = 0;
    #1;
    while (reg_wait) begin @(negedge clk); #1; stalls++; end
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(output logic [31:0] d);
    reg_rd = 1; @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic await_cmds(input string req);
    for (int i = 0; i < 30 && exp_q.size() != 0; i++) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s missing command act=none exp=%0d", req, exp_q[0]);
      exp_q.delete();
    end
  endtask

  // monitor: 1 start, 2 repeated start, 3 stop
  always @(negedge clk) begin
    int code;
    int e;
    code = 0;
    if (!rst) begin
      if (cmd_start) code = 1; else if (cmd_rstart) code = 2; else if (cmd_stop) code = 3;
      if (code != 0) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R6/R9/R10 unexpected command act=%0d exp=none", code);
        end else begin
          e = exp_q.pop_front();
          if (e != code) begin
            fails++;
            $display("FAIL R6/R9/R10 command act=%0d exp=%0d", code, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3); rst = 0; idle(1);
    // R1 reset state
    rd(v); chk("R1 word", v, 0);
    chk("R1 flags", {master_active, tc_flag, tcr_flag}, 0);
    // R2 layout, high bits read zero
    wr(32'hF800_0FA5); rd(v); chk("R2 layout", v, 32'h0000_0FA5);
    chk("R2 pins", {tgt_addr, addr_10b, hdr_only, dir_read}, {10'h3A5, 1'b1, 1'b0, 1'b1});
    // R3 set-only bits
    wr(32'h0000_8000); wr(32'h0); rd(v); chk("R3 nack kept", v, 32'h0000_8000);
    ev_addr_match = 1; idle(1); ev_addr_match = 0; rd(v); chk("R7 nack match clr", v, 0);
    wr(32'h0400_0000); rd(v); chk("R3 pec set", v, 32'h0400_0000);
    ev_stop_det = 1; idle(1); ev_stop_det = 0; rd(v); chk("R7 pec stop clr", v, 0);
    // R5 reload blocks start and pec
    wr(32'h0100_0000); wr(32'h0500_2000); idle(4); rd(v); chk("R5 blocked", v, 32'h0100_0000);
    wr(32'h0);
    // R6 wait for free bus, R4 lock
    bus_busy = 1; wr(32'h0202_2052); idle(5);
    rd(v); chk("R6 pending", v, 32'h0202_2052);
    wr(32'h0202_2C52); rd(v); chk("R4 lock", v, 32'h0202_2052);
    exp_q.push_back(1); bus_busy = 0; await_cmds("R6");
    ev_addr_sent = 1; idle(1); ev_addr_sent = 0;
    chk("R8 load", bytes_left, 2);
    rd(v); chk("R6 start clr", v[13], 0);
    // R9 auto-end
    exp_q.push_back(3);
    ev_byte_done = 1; idle(2); ev_byte_done = 0; await_cmds("R9");
    chk("R9 active", master_active, 1);
    ev_stop_det = 1; idle(1); ev_stop_det = 0; chk("R9 idle", master_active, 0);
    // R10 and R11 master read
    exp_q.push_back(1); wr(32'h0001_2452); await_cmds("R10 start");
    ev_addr_sent = 1; idle(1); ev_addr_sent = 0; idle(1);
    chk("R11 last nack", nack_out, 1);
    ev_byte_done = 1; idle(1); ev_byte_done = 0; idle(3);
    chk("R10 tc", tc_flag, 1);
    chk("R11 nack bit", nack_out, 0);
    exp_q.push_back(2); wr(32'h0001_2452); await_cmds("R10 rstart");
    ev_addr_sent = 1; idle(1); ev_addr_sent = 0;
    ev_byte_done = 1; idle(1); ev_byte_done = 0; idle(3);
    chk("R10 tc again", tc_flag, 1);
    exp_q.push_back(3); wr(32'h0000_4000); await_cmds("R10 stop");
    rd(v); chk("R7 stop held", v, 32'h0000_4000);
    ev_stop_det = 1; idle(1); ev_stop_det = 0;
    rd(v); chk("R7 stop clr", v, 0);
    // R8 reload stall
    exp_q.push_back(1); wr(32'h0002_2052); wr(32'h0102_2052); await_cmds("R8 start");
    ev_addr_sent = 1; idle(1); ev_addr_sent = 0;
    ev_byte_done = 1; idle(2); ev_byte_done = 0; idle(6);
    chk("R8 tcr", tcr_flag, 1);
    chk("R8 no end", {tc_flag, master_active}, 2'b01);
    exp_q.push_back(3);
    wr(32'h0203_0052);
    chk("R8 reload cnt", bytes_left, 3);
    chk("R8 resumed", tcr_flag, 0);
    ev_byte_done = 1; idle(3); ev_byte_done = 0; await_cmds("R8 end");
    ev_stop_det = 1; idle(1); ev_stop_det = 0;
    // R6, R7 enable low clears everything
    bus_busy = 1; wr(32'h0400_E000); rd(v); chk("R3 all set", v, 32'h0400_E000);
    en = 0; idle(1); en = 1; rd(v); chk("R7 en clr", v, 0);
    bus_busy = 0; idle(4);
    // R6 timeout and arbitration loss
    bus_busy = 1; wr(32'h0000_2052);
    ev_timeout = 1; idle(1); ev_timeout = 0; rd(v); chk("R6 timeout clr", v, 32'h52);
    bus_busy = 0; idle(2);
    exp_q.push_back(1); wr(32'h0000_2052); await_cmds("R6 arb");
    ev_arb_lost = 1; idle(1); ev_arb_lost = 0;
    chk("R6 arb inactive", master_active, 0);
    rd(v); chk("R6 arb clr", v, 32'h52);
    // R11 error-check byte ack
    wr(32'h0000_8000); idle(1); chk("R11 nack bit", nack_out, 1);
    wr(32'h0400_8000); pec_phase = 1; pec_bad = 0; idle(2); chk("R11 pec good", nack_out, 0);
    pec_bad = 1; idle(2); chk("R11 pec bad", nack_out, 1);
    pec_bad = 0; ev_pec_done = 1; idle(1); ev_pec_done = 0; idle(1);
    chk("R11 pec cleared", nack_out, 1);
    pec_phase = 0; ev_nack_sent = 1; idle(1); ev_nack_sent = 0; idle(1);
    chk("R7 nack sent clr", nack_out, 0);
    // R12 write hold-off
    wr(32'h0000_0111); wr(32'h0000_0222);
    chk("R12 stall", stalls, 3);
    rd(v); chk("R12 applied", v, 32'h0000_0222);
    idle(5);
    checks++;
    if (exp_q.size() != 0) begin fails++; $display("FAIL R9 queue act=%0d exp=0", exp_q.size()); end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule